// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host access to a small bank of processor configuration registers through two 8-bit I/O ports. The host first writes a register number to the index port, then reads or writes the data port. Each index write is good for one data-port access only. After that access the index is spent, and the host must write it again before the next access.

A single control register is always reachable. Bit 4 of that register is the unlock bit. Every other register in the bank answers only while the unlock bit is set. Software normally works in four steps: it saves the control register, sets the unlock bit, performs its access, and then writes the saved value back.

One of the gated registers is the graphics configuration register. Its two low bits select which 1 GiB window of the 32-bit address space holds the graphics registers. The block drives that base address on an output for the memory and display logic.

Top module: `cfgport_top`

## Requirements
- R1: After reset the control register (index 0xC3) reads 0x00, so the unlock bit is clear. The graphics configuration register (index 0xB8) reads 0x01. The spare registers (indices 0xE8 to 0xEB) read 0x00. No index is held. `gfx_base` is 0x4000_0000.
- R2: A write to port 0x22 stores the written byte as the current index, replacing any earlier index. The next access to port 0x23 acts on that register.
- R3: A read or write at port 0x23 uses up the index. A later port 0x23 access with no new index write reads 0xFF, and a write in that state changes nothing.
- R4: The control register at index 0xC3 can be read and written whether or not the unlock bit (bit 4) is set. All 8 bits are stored.
- R5: While the unlock bit is clear, the graphics configuration register and the spare registers read 0xFF through port 0x23. Writes to them have no effect.
- R6: While the unlock bit is set, the graphics configuration register and the spare registers can be read and written. All 8 bits are stored.
- R7: `gfx_base` bits [31:30] equal bits [1:0] of the graphics configuration register, and bits [29:0] are zero. The output changes in the clock cycle after the data-port write.
- R8: An index that names no register reads 0xFF, and a write to it has no effect, whatever the state of the unlock bit.
- R9: Read data is combinational and appears in the same cycle as the address. Any port address other than 0x23 reads 0xFF. Strobes at addresses other than 0x22 and 0x23 are ignored.
- R10: The control register can be rewritten at any point in a save, unlock, access, restore sequence. Writing back a value with bit 4 clear closes the gate again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | One-cycle read strobe |
| io_wr | input | 1 | One-cycle write strobe |
| io_rdata | output | 8 | Combinational read data |
| gfx_base | output | 32 | Graphics register base address |

## Verification
A spent index that stayed live would show up at once. The second read after one index write would return register data instead of 0xFF in the same cycle. A wrong unlock state makes a gated register read 0xFF when it should not, or show data when it should not, on the first data access after the control register write. A lost or stray write to the graphics configuration register moves `gfx_base` one cycle after the write. It also changes the value read back the next time the register is read.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int unsigned DW = 8;
  localparam logic [7:0] IDX_PORT  = 8'h22;
  localparam logic [7:0] DATA_PORT = 8'h23;
  localparam logic [7:0] CTRL_IDX  = 8'hC3;
  localparam logic [7:0] GFX_IDX   = 8'hB8;
  localparam logic [7:0] IDLE_DATA = 8'hFF;

  typedef struct packed {
    logic idx_wr;
    logic dat_rd;
    logic dat_wr;
    logic dat_sel;
  } port_cmd_t;
endpackage

// File: rtl/cfgport_rst_sync.sv
module cfgport_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfgport_decode.sv
module cfgport_decode
  import cfgport_pkg::*;
#(
  parameter logic [7:0] INDEX_ADDR = IDX_PORT,
  parameter logic [7:0] DATA_ADDR  = DATA_PORT
) (
  input  logic      [7:0] io_addr,
  input  logic            io_rd,
  input  logic            io_wr,
  output port_cmd_t       cmd
);
  logic hit_idx;
  logic hit_dat;

  always_comb begin
    hit_idx     = (io_addr == INDEX_ADDR);
    hit_dat     = (io_addr == DATA_ADDR);
    cmd.idx_wr  = hit_idx & io_wr;
    cmd.dat_rd  = hit_dat & io_rd;
    cmd.dat_wr  = hit_dat & io_wr;
    cmd.dat_sel = hit_dat;
  end
endmodule

// File: rtl/cfgport_index.sv
module cfgport_index
  import cfgport_pkg::*;
#(
  parameter int unsigned IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic          dat_access,
  input  logic [IW-1:0] wdata,
  output logic [IW-1:0] idx,
  output logic          idx_valid
);
  logic [IW-1:0] idx_q, idx_d;
  logic          vld_q, vld_d;
  logic          idx_en;

  always_comb begin
    idx_en = idx_wr;
    idx_d  = wdata;
    vld_d  = vld_q;
    if (idx_wr)          vld_d = 1'b1;
    else if (dat_access) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign idx       = idx_q;
  assign idx_valid = vld_q;

  // R2: an index write is held and armed on the following cycle
  assert_index_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (idx_valid && idx == $past(wdata)));

  // R3: a data access with no fresh index leaves the port disarmed
  assert_index_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_access && !idx_wr) |=> !idx_valid);
endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank
  import cfgport_pkg::*;
#(
  parameter int unsigned NUM_SPARE  = 4,
  parameter logic [7:0]  SPARE_BASE = 8'hE8,
  parameter int unsigned UNLOCK_BIT = 4,
  parameter logic [7:0]  CTRL_RST   = 8'h00,
  parameter logic [7:0]  GFX_RST    = 8'h01,
  parameter int unsigned SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [7:0]       idx,
  input  logic             idx_valid,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_value,
  output logic             rd_ok,
  output logic [SEL_W-1:0] base_sel
);
  localparam int unsigned SPW = (NUM_SPARE > 1) ? $clog2(NUM_SPARE) : 1;

  logic [DW-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0] gfx_q, gfx_d;
  logic          ctrl_en, gfx_en;
  logic          unlocked;
  logic          hit_ctrl, hit_gfx, hit_spare;
  logic [SPW-1:0] spare_sel;
  logic [DW-1:0] spare_q [NUM_SPARE];
  logic [NUM_SPARE-1:0] spare_hit;
  logic [NUM_SPARE-1:0] spare_en;

  assign unlocked = ctrl_q[UNLOCK_BIT];

  always_comb begin
    hit_ctrl  = idx_valid && (idx == CTRL_IDX);
    hit_gfx   = idx_valid && (idx == GFX_IDX);
    hit_spare = idx_valid && (|spare_hit);
    ctrl_en   = wr_req && hit_ctrl;
    gfx_en    = wr_req && hit_gfx && unlocked;
    ctrl_d    = wdata;
    gfx_d     = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gfx_q <= GFX_RST;
    else if (gfx_en) gfx_q <= gfx_d;
  end

  for (genvar g = 0; g < NUM_SPARE; g++) begin : g_spare
    logic [DW-1:0] sp_d;
    always_comb begin
      spare_hit[g] = (idx == (SPARE_BASE + 8'(g)));
      spare_en[g]  = wr_req && idx_valid && spare_hit[g] && unlocked;
      sp_d         = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           spare_q[g] <= '0;
      else if (spare_en[g]) spare_q[g] <= sp_d;
    end
  end

  always_comb begin
    spare_sel = '0;
    for (int i = 0; i < NUM_SPARE; i++) begin
      if (spare_hit[i]) spare_sel = SPW'(i);
    end
  end

  always_comb begin
    rd_value = IDLE_DATA;
    rd_ok    = 1'b0;
    if (hit_ctrl) begin
      rd_value = ctrl_q;
      rd_ok    = 1'b1;
    end else if (hit_gfx && unlocked) begin
      rd_value = gfx_q;
      rd_ok    = 1'b1;
    end else if (hit_spare && unlocked) begin
      rd_value = spare_q[spare_sel];
      rd_ok    = 1'b1;
    end
  end

  assign base_sel = gfx_q[SEL_W-1:0];

  // R4: the control register takes every write aimed at it
  assert_ctrl_always_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && idx_valid && idx == CTRL_IDX) |=> (ctrl_q == $past(wdata)));

  // R5: a locked write leaves the graphics configuration unchanged
  assert_gfx_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !ctrl_q[UNLOCK_BIT]) |=> $stable(gfx_q));

  // R6: an unlocked write to the graphics configuration is stored
  assert_gfx_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && idx_valid && idx == GFX_IDX && ctrl_q[UNLOCK_BIT])
      |=> (gfx_q == $past(wdata)));

  // R8: at most one register is addressed by any index
  assert_single_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_ctrl, hit_gfx, hit_spare}));
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int unsigned NUM_SPARE  = 4,
  parameter logic [7:0]  SPARE_BASE = 8'hE8,
  parameter int unsigned UNLOCK_BIT = 4,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SEL_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        io_addr,
  input  logic [DW-1:0]     io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [DW-1:0]     io_rdata,
  output logic [ADDR_W-1:0] gfx_base
);
  localparam int unsigned LOW_W = ADDR_W - SEL_W;

  logic             rst_sync_n;
  port_cmd_t        cmd;
  logic [7:0]       idx;
  logic             idx_valid;
  logic [DW-1:0]    bank_val;
  logic             bank_ok;
  logic [SEL_W-1:0] sel;
  logic             dat_access;

  cfgport_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cfgport_decode u_dec (
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .cmd(cmd)
  );

  assign dat_access = cmd.dat_rd | cmd.dat_wr;

  cfgport_index #(.IW(8)) u_idx (
    .clk(clk), .rst_n(rst_sync_n), .idx_wr(cmd.idx_wr),
    .dat_access(dat_access), .wdata(io_wdata),
    .idx(idx), .idx_valid(idx_valid)
  );

  cfgport_bank #(
    .NUM_SPARE(NUM_SPARE), .SPARE_BASE(SPARE_BASE),
    .UNLOCK_BIT(UNLOCK_BIT), .SEL_W(SEL_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_req(cmd.dat_wr),
    .idx(idx), .idx_valid(idx_valid), .wdata(io_wdata),
    .rd_value(bank_val), .rd_ok(bank_ok), .base_sel(sel)
  );

  always_comb begin
    io_rdata = IDLE_DATA;
    if (cmd.dat_sel && bank_ok) io_rdata = bank_val;
  end

  assign gfx_base = {sel, {LOW_W{1'b0}}};

  // R3: a data read with no armed index returns the idle pattern
  assert_spent_read_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd.dat_rd && !idx_valid) |-> (io_rdata == IDLE_DATA));

  // R9: reads away from the data port return the idle pattern
  assert_other_port_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && io_addr != DATA_PORT) |-> (io_rdata == IDLE_DATA));

  // R7: the base output tracks the last accepted select value
  assert_base_follow_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cmd.dat_wr) |=> $stable(gfx_base));
endmodule

// File: tb/sim_cfgport_top.sv
module sim_cfgport_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  io_addr;
  logic [7:0]  io_wdata;
  logic        io_rd;
  logic        io_wr;
  logic [7:0]  io_rdata;
  logic [31:0] gfx_base;

  int n_chk;
  int n_fail;

  cfgport_top u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata), .gfx_base(gfx_base)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: {is_read, port, data_or_expected, requirement}
  localparam int NV = 44;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'h23, 8'hFF, 4'd3},   // R3 no index yet
    {1'b0, 8'h22, 8'hC3, 4'd0},
    {1'b1, 8'h23, 8'h00, 4'd1},   // R1 control reset
    {1'b0, 8'h22, 8'hB8, 4'd0},
    {1'b1, 8'h23, 8'hFF, 4'd5},   // R5 locked read
    {1'b0, 8'h22, 8'hB8, 4'd0},
    {1'b0, 8'h23, 8'h56, 4'd0},   // locked write
    {1'b0, 8'h22, 8'hC3, 4'd0},
    {1'b0, 8'h23, 8'h10, 4'd0},   // R4 unlock
    {1'b0, 8'h22, 8'hC3, 4'd0},
    {1'b1, 8'h23, 8'h10, 4'd4},   // R4 readback
    {1'b0, 8'h22, 8'hB8, 4'd0},
    {1'b1, 8'h23, 8'h01, 4'd5},   // R5 locked write dropped
    {1'b0, 8'h22, 8'hE8, 4'd0},
    {1'b1, 8'h23, 8'h00, 4'd1},   // R1 spare reset
    {1'b0, 8'h22, 8'hB8, 4'd0},
    {1'b0, 8'h23, 8'h03, 4'd0},
    {1'b0, 8'h22, 8'hB8, 4'd0},
    {1'b1, 8'h23, 8'h03, 4'd6},   // R6 unlocked write
    {1'b0, 8'h23, 8'hAA, 4'd0},   // no index: dropped
    {1'b0, 8'h22, 8'hB8, 4'd0},
    {1'b1, 8'h23, 8'h03, 4'd3},   // R3 write without index dropped
    {1'b1, 8'h23, 8'hFF, 4'd3},   // R3 index spent by read
    {1'b0, 8'h22, 8'hEB, 4'd0},
    {1'b0, 8'h23, 8'h5A, 4'd0},
    {1'b0, 8'h22, 8'hEB, 4'd0},
    {1'b1, 8'h23, 8'h5A, 4'd6},   // R6 spare register
    {1'b0, 8'h22, 8'h7F, 4'd0},
    {1'b0, 8'h23, 8'h11, 4'd0},
    {1'b0, 8'h22, 8'h7F, 4'd0},
    {1'b1, 8'h23, 8'hFF, 4'd8},   // R8 unknown index
    {1'b0, 8'h22, 8'hB8, 4'd0},
    {1'b0, 8'h22, 8'hC3, 4'd0},
    {1'b1, 8'h23, 8'h10, 4'd2},   // R2 later index wins
    {1'b1, 8'h22, 8'hFF, 4'd9},   // R9 index port read
    {1'b0, 8'h24, 8'hB8, 4'd0},   // stray port write ignored
    {1'b1, 8'h23, 8'hFF, 4'd9},   // R9 stray write armed nothing
    {1'b0, 8'h22, 8'hC3, 4'd0},
    {1'b0, 8'h23, 8'h00, 4'd0},   // R10 restore saved value
    {1'b0, 8'h22, 8'hEB, 4'd0},
    {1'b1, 8'h23, 8'hFF, 4'd10},  // R10 gate closed again
    {1'b0, 8'h22, 8'hC3, 4'd0},
    {1'b1, 8'h23, 8'h00, 4'd10},  // R10 control still open
    {1'b1, 8'h20, 8'hFF, 4'd9}    // R9 unrelated port read
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // starts and ends on a falling edge
  task automatic access(input logic rd, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] q);
    io_addr  = a;
    io_wdata = rd ? 8'h00 : d;
    io_rd    = rd;
    io_wr    = ~rd;
    #2 q = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
    io_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] q;
    n_chk = 0;
    n_fail = 0;
    io_addr = 8'h00; io_wdata = 8'h00; io_rd = 1'b0; io_wr = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    check("R1 base after reset", gfx_base, 32'h4000_0000);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][20], VEC[i][19:12], VEC[i][11:4], q);
      if (VEC[i][20])
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), {24'h0, q}, {24'h0, VEC[i][11:4]});
    end

    // R7: base output follows the select field one cycle after the write
    access(1'b0, 8'h22, 8'hC3, q);
    access(1'b0, 8'h23, 8'h10, q);
    access(1'b0, 8'h22, 8'hB8, q);
    check("R7 base before write", gfx_base, 32'hC000_0000);
    access(1'b0, 8'h23, 8'hFE, q);
    check("R7 base select 2", gfx_base, 32'h8000_0000);
    access(1'b0, 8'h22, 8'hB8, q);
    access(1'b1, 8'h23, 8'h00, q);
    check("R6 full byte stored", {24'h0, q}, 32'h0000_00FE);

    // R5: locked write leaves the base output unchanged
    access(1'b0, 8'h22, 8'hC3, q);
    access(1'b0, 8'h23, 8'h00, q);
    access(1'b0, 8'h22, 8'hB8, q);
    access(1'b0, 8'h23, 8'h00, q);
    check("R5 locked write keeps base", gfx_base, 32'h8000_0000);

    // R3: index spent by a write, second write dropped
    access(1'b0, 8'h22, 8'hC3, q);
    access(1'b0, 8'h23, 8'h10, q);
    access(1'b0, 8'h23, 8'h00, q);
    access(1'b0, 8'h22, 8'hC3, q);
    access(1'b1, 8'h23, 8'h00, q);
    check("R3 second write dropped", {24'h0, q}, 32'h0000_0010);

    // R1: reset mid-run restores every register
    do_reset();
    check("R1 base after second reset", gfx_base, 32'h4000_0000);
    access(1'b1, 8'h23, 8'h00, q);
    check("R1 index cleared by reset", {24'h0, q}, 32'h0000_00FF);
    access(1'b0, 8'h22, 8'hC3, q);
    access(1'b1, 8'h23, 8'h00, q);
    check("R1 control after second reset", {24'h0, q}, 32'h0000_0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule